// File: doc/BRIEF.md
# Video Scrambler and NRZI Serializer

This block converts a stream of 10-bit parallel video words into one serial bit stream. It shifts out ten bits per word on a bit clock that runs ten times faster than the word rate. Each bit then goes through a self-synchronizing scrambler built on the polynomial x^9 + x^4 + 1, which spreads the spectrum and lowers the DC content. A transition encoder built on x + 1 then turns the scrambled NRZ stream into NRZI.

A bypass control sends the raw serialized bits straight to the output, skipping both coding stages. A lock indication from the clock source mutes the output while the clock is not trusted. The block drives the serial bit and its complement. The upstream logic raises a one-cycle load strobe together with each word, once every ten bit clocks.

Top module: `vid_serial_coder`

## Requirements
- R1: A word presented with `word_load` high at a bit-clock edge is captured at that edge. Its ten bits go out on the next ten bit clocks. The next load is expected exactly ten bit clocks after the previous one, so words follow each other with no gap.
- R2: Bits of a word are sent least significant bit first. The bit at word position i goes into the coding stages i bit clocks after the load edge. It appears on `ser_out` one bit clock later.
- R3: With `bypass` low, each scrambled bit equals the data bit XOR the scrambled bits produced 4 and 9 bit times earlier. The 9-bit history of scrambled bits is all zero after reset.
- R4: With `bypass` low, the NRZI stage inverts its output level for a scrambled 1 and holds the level for a scrambled 0. The level register starts at 0 after reset. `ser_out` shows the level that results after the bit is applied.
- R5: With `bypass` high and `locked` high, `ser_out` carries the raw serialized bit, one bit clock after it leaves the word register.
- R6: While `locked` is low at a bit-clock edge, `ser_out` is 0 after that edge, whatever the data and `bypass`.
- R7: `ser_out_n` is always the inverse of `ser_out`.
- R8: While `rst_n` is low at a clock edge, the word register, the scrambler history, the NRZI level and the output register are cleared. After reset `ser_out` is 0 and `ser_out_n` is 1.
- R9: The scrambler history and the NRZI level keep advancing on every bit clock, whether bypass is set or the output is muted. Changing `bypass` never clears them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| par_word | input | 10 | Parallel word to serialize |
| word_load | input | 1 | Capture strobe for `par_word`, one cycle per ten |
| bypass | input | 1 | High: send raw bits, skip scrambler and NRZI |
| locked | input | 1 | Clock-lock indication; low mutes the output |
| ser_out | output | 1 | Serial data |
| ser_out_n | output | 1 | Complement of serial data |

## Verification
The bench runs a bit-level model of the shifter, scrambler and NRZI stage. It compares every output bit for several kinds of input. All-zero words must give a constant low line, because a zero history stays zero. All-one words and a walking single one show the bit order and the effect of each tap. A full count through all 1024 word values with coding enabled exercises both feedback taps against every data pattern. Bypass runs are checked against the raw bits, and runs that toggle bypass word by word show that the coding state keeps advancing and is never cleared. Drops of lock in the middle of a word confirm the mute and that coding resumes where it left off.

// File: rtl/vid_serial_pkg.sv
// Shared constants for the video serial coder.
// Assumes a 10-bit word and a 9-stage scrambler with a tap at stage 4.
package vid_serial_pkg;
    localparam int WORD_W_DEF  = 10;
    localparam int SCR_LEN_DEF = 9;
    localparam int SCR_TAP_DEF = 4;

    // Selects which bit reaches the output for the given mode flags.
    function automatic logic pick_out(input logic lk, input logic byp,
                                      input logic raw, input logic coded);
        if (!lk)
            return 1'b0;
        return byp ? raw : coded;
    endfunction
endpackage

// File: rtl/vsc_shifter.sv
// Parallel-to-serial word shifter.
// Captures a word on a load strobe and presents one bit per clock,
// least significant bit first. Assumes a load once every WORD_W clocks.
module vsc_shifter #(
    parameter int WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    output logic              bit_out
);
    localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    logic [WORD_W-1:0] sh_q;
    logic [CNT_W-1:0]  phase_q;
    logic              primed_q;

    // Load a new word or move the current one down by one bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sh_q <= '0;
        else if (load)
            sh_q <= word;
        else
            sh_q <= {1'b0, sh_q[WORD_W-1:1]};
    end

    // Count the bit position within the current word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= '0;
            primed_q <= 1'b0;
        end else if (load) begin
            phase_q  <= '0;
            primed_q <= 1'b1;
        end else if (phase_q != LAST) begin
            phase_q  <= phase_q + 1'b1;
        end
    end

    assign bit_out = sh_q[0];

    // Loads after the first arrive once every WORD_W bit clocks.
    assert_load_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && load) |-> (phase_q == LAST));

    // The first bit out after a load is the word's least significant bit.
    assert_lsb_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (bit_out == $past(word[0])));
endmodule

// File: rtl/vsc_scrambler.sv
// Self-synchronizing scrambler: each output bit is the input bit XOR
// the outputs from TAP and LEN bit times earlier. History clears on reset
// and advances every clock; no other control clears it.
module vsc_scrambler #(
    parameter int LEN = 9,
    parameter int TAP = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [LEN-1:0] hist_q;   // hist_q[k] = output from k+1 bit times ago

    // Feedback from the two tap positions.
    always_comb begin
        dout = din ^ hist_q[TAP-1] ^ hist_q[LEN-1];
    end

    // Push the newest scrambled bit into the history.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hist_q <= '0;
        else
            hist_q <= {hist_q[LEN-2:0], dout};
    end

    // A zero input with a zero history keeps the history at zero.
    assert_zero_stays_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!din && hist_q == '0) |=> (hist_q == '0));
endmodule

// File: rtl/vsc_nrzi.sv
// NRZ to NRZI encoder (x+1): a one inverts the line level and a zero
// holds it. Presents the level after the current bit has been applied.
module vsc_nrzi (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic level_next
);
    logic lvl_q;

    // Next level after this bit.
    always_comb begin
        level_next = lvl_q ^ din;
    end

    // Store the line level.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lvl_q <= 1'b0;
        else
            lvl_q <= level_next;
    end

    assign level = lvl_q;
endmodule

// File: rtl/vid_serial_coder.sv
// Top: shifter -> scrambler -> NRZI, with a bypass mux, a lock mute and
// registered true/complement outputs. Coding state keeps advancing in
// every mode. Assumes word_load arrives once every WORD_W bit clocks.
module vid_serial_coder
    import vid_serial_pkg::*;
#(
    parameter int WORD_W  = WORD_W_DEF,
    parameter int SCR_LEN = SCR_LEN_DEF,
    parameter int SCR_TAP = SCR_TAP_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] par_word,
    input  logic              word_load,
    input  logic              bypass,
    input  logic              locked,
    output logic              ser_out,
    output logic              ser_out_n
);
    logic raw_bit;
    logic scr_bit;
    logic nrzi_level;
    logic nrzi_next;
    logic out_q;

    vsc_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (word_load),
        .word    (par_word),
        .bit_out (raw_bit)
    );

    vsc_scrambler #(.LEN(SCR_LEN), .TAP(SCR_TAP)) u_scr (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw_bit),
        .dout  (scr_bit)
    );

    vsc_nrzi u_nrzi (
        .clk        (clk),
        .rst_n      (rst_n),
        .din        (scr_bit),
        .level      (nrzi_level),
        .level_next (nrzi_next)
    );

    // Register the selected, possibly muted, line bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_q <= 1'b0;
        else
            out_q <= pick_out(locked, bypass, raw_bit, nrzi_next);
    end

    assign ser_out   = out_q;
    assign ser_out_n = ~out_q;

    // A lock drop mutes the output on the next edge.
    assert_mute_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |=> !ser_out);

    // Bypass passes the raw bit through.
    assert_bypass_raw_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && bypass) |=> (ser_out == $past(raw_bit)));

    // A scrambled zero holds the line level.
    assert_nrzi_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !bypass && !scr_bit) |=> (ser_out == $past(nrzi_level)));

    // A scrambled one inverts the line level.
    assert_nrzi_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !bypass && scr_bit) |=> (ser_out != $past(nrzi_level)));
endmodule

// File: tb/tb_vid_serial_coder.sv
module tb_vid_serial_coder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] par_word = '0;
    logic       word_load = 1'b0;
    logic       bypass = 1'b0;
    logic       locked = 1'b0;
    logic       ser_out;
    logic       ser_out_n;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    // Bench model state, built from the requirements.
    logic [9:0] m_sh = '0;
    logic [8:0] m_hist = '0;
    logic       m_lvl = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    vid_serial_coder dut (
        .clk(clk), .rst_n(rst_n), .par_word(par_word), .word_load(word_load),
        .bypass(bypass), .locked(locked), .ser_out(ser_out), .ser_out_n(ser_out_n)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // One bit clock: drive inputs, advance the model, check after the edge.
    task automatic tick(input logic ld, input logic [9:0] w, input logic byp,
                        input logic lk, input string tag);
        logic d, s, n, e;
        word_load = ld; par_word = w; bypass = byp; locked = lk;
        d = m_sh[0];
        s = d ^ m_hist[3] ^ m_hist[8];
        n = m_lvl ^ s;
        e = !lk ? 1'b0 : (byp ? d : n);
        m_hist = {m_hist[7:0], s};
        m_lvl = n;
        m_sh = ld ? w : {1'b0, m_sh[9:1]};
        @(posedge clk);
        cycles++;
        @(negedge clk);
        check(!lk ? "R6" : (tag != "" ? tag : (byp ? "R5" : "R3")), ser_out, e);
        check("R7", ser_out_n, ~ser_out);
    endtask

    task automatic send(input logic [9:0] w, input logic byp, input logic lk,
                        input string tag);
        for (int i = 0; i < 10; i++) tick(i == 0, w, byp, lk, tag);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; word_load = 1'b0; locked = 1'b0;
        repeat (3) begin @(posedge clk); cycles++; end
        @(negedge clk);
        m_sh = '0; m_hist = '0; m_lvl = 1'b0;
        check("R8", ser_out, 1'b0);
        check("R8", ser_out_n, 1'b1);
        rst_n = 1'b1;
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        // R3/R4: zeros from a clear history give a constant low line.
        for (int k = 0; k < 3; k++) send(10'h000, 1'b0, 1'b1, "R3");
        // R2/R5: LSB first in bypass with a single one.
        send(10'h001, 1'b1, 1'b1, "R2");
        // R1/R2: walking one through every position, raw and coded.
        for (int p = 0; p < 10; p++) send(10'(1 << p), 1'b1, 1'b1, "R1");
        for (int p = 0; p < 10; p++) send(10'(1 << p), 1'b0, 1'b1, "R4");
        // R3/R4: all ones, then every word value with coding on.
        for (int k = 0; k < 4; k++) send(10'h3FF, 1'b0, 1'b1, "R4");
        for (int v = 0; v < 1024; v++) send(10'(v), 1'b0, 1'b1, "R3");
        // R5: every word value in bypass.
        for (int v = 0; v < 1024; v++) send(10'(v ^ 10'h155), 1'b1, 1'b1, "R5");
        // R9: bypass toggled per word; coding state must carry over.
        for (int v = 0; v < 200; v++) send(10'(v * 37), v[0], 1'b1, "R9");
        // R6/R9: lock dropped mid-word, coding resumes afterwards.
        for (int v = 0; v < 50; v++) begin
            for (int i = 0; i < 10; i++)
                tick(i == 0, 10'(v * 91 + 5), 1'b0, !(i >= 3 && i <= 6 && v[1]), "R9");
        end
        // R8: reset mid-stream clears everything.
        send(10'h2A5, 1'b0, 1'b1, "R3");
        do_reset();
        for (int k = 0; k < 2; k++) send(10'h000, 1'b0, 1'b1, "R8");
        send(10'h3C1, 1'b0, 1'b1, "R3");
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule